// File: doc/BRIEF.md
# HDB3 / AMI Transmit Line Encoder

This block turns a unipolar transmit bit stream, one bit per clock at the 2.048 Mbit/s line rate, into a pair of registered rail enables for a bipolar line driver. Each clock produces one symbol: a pulse on the positive rail, a pulse on the negative rail, or no pulse. By default, ones become pulses of alternating sign and zeros stay quiet. When zero substitution is switched on, each run of four zeros is replaced by a code that contains a deliberate sign violation. This keeps pulse density up for the far-end clock recovery.

Three other sources can drive the rails. A dual-rail mode passes externally coded rail data straight through, with an optional active-low input sense. A remote loopback sends the recovered receive rails back to the line. An alarm-indication override sends continuous ones of alternating sign. The override has priority over every other source. It continues from the encoder's own sign history, so that no false violation appears on entry or exit.

Top module: `hdb3_line_encoder`

## Requirements
- R1: With substitution off, in single-rail mode a one is sent as a pulse on exactly one rail, with the sign opposite to the previous pulse (line_p=1 is positive, line_n=1 is negative). A zero is sent as no pulse on either rail, however long the run of zeros.
- R2: In single-rail mode, a bit sampled on tx_data at clock edge n appears on line_p/line_n right after edge n+4: four look-ahead stages and one output register.
- R3: With hdb3_en=1, each run of four zeros that is not already part of a code is sent as 000V or B00V. It is 000V when the last pulse has the opposite sign to the last violation and was not itself a violation, and B00V otherwise. B follows the alternation rule. V repeats the sign of the pulse just before it.
- R4: While rst_n is low, both rails are 0. After reset, the history counts the last pulse as negative and the last violation as positive. The first pulse is therefore positive and the first substitution is 000V.
- R5: With dual_rail=1 (and no override or loopback), {tx_p_in, tx_n_in} reach {line_p, line_n} one clock later. hdb3_en has no effect in this mode.
- R6: In dual-rail mode with mode2_neg=1, both rail inputs are taken as active-low, so each line rail is the inverse of its input.
- R7: With loop_remote=1 and ais_tx=0, {rx_p, rx_n} reach the line rails one clock later, and the transmit inputs are ignored.
- R8: With ais_tx=1, each clock sends a single-rail pulse of alternating sign. This applies whatever loop_remote, dual_rail and the data inputs are.
- R9: The override's pulse signs continue from the encoder's sign history. On entry and on exit from the override, with all-ones data, no two consecutive pulses share a sign.
- R10: Whenever the encoder or the override drives the line, the two rails are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one symbol per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 1 | Unipolar transmit bit (single-rail mode) |
| hdb3_en | input | 1 | Enables four-zero substitution |
| dual_rail | input | 1 | Selects direct rail pass-through |
| mode2_neg | input | 1 | Dual-rail inputs are active-low when 1 |
| tx_p_in | input | 1 | Positive-rail transmit input (dual-rail mode) |
| tx_n_in | input | 1 | Negative-rail transmit input (dual-rail mode) |
| loop_remote | input | 1 | Sends received rails back to the line |
| rx_p | input | 1 | Recovered positive receive rail |
| rx_n | input | 1 | Recovered negative receive rail |
| ais_tx | input | 1 | Forces alternating all-ones on the line |
| line_p | output | 1 | Registered positive pulse enable |
| line_n | output | 1 | Registered negative pulse enable |

## Verification
The bench builds the encoder with RUN_LEN=4, the run length the line code defines. With this value the 48-symbol stimulus streams contain back-to-back substitutions, runs that begin right after a code, and codes whose selection depends on an odd or even pulse count since the last violation. A reference encoder in the bench counts pulses since the last violation, instead of keeping sign history, and predicts every symbol of each stream. Directed sequences cover the override's sign continuity across entry and exit, and the pass-through paths.

// File: rtl/hdb3_enc_pkg.sv
package hdb3_enc_pkg;

  // Look-ahead slot state: a plain slot may start a substitution, a taken
  // slot is already covered by one, vpend marks the slot that becomes V.
  typedef enum logic [1:0] {
    TAG_PLAIN = 2'd0,
    TAG_TAKEN = 2'd1,
    TAG_VPEND = 2'd2
  } slot_tag_e;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_VIOL = 2'd2
  } line_sym_e;

  // B00V is needed when the pulses since the last violation are even.
  function automatic logic want_bpulse(input logic mark_pol, input logic viol_pol,
                                       input logic mark_was_v);
    return (mark_pol == viol_pol) || mark_was_v;
  endfunction

  // {p, n} for a symbol of the given sign (1 = positive).
  function automatic logic [1:0] sym_to_rails(input line_sym_e s, input logic pol);
    if (s == SYM_ZERO) return 2'b00;
    return pol ? 2'b10 : 2'b01;
  endfunction

  // Tag a slot gets when shifting one place towards the head.
  function automatic slot_tag_e slot_next_tag(input logic clear, input logic start,
                                               input logic becomes_v, input slot_tag_e cur);
    if (clear) return TAG_PLAIN;
    if (start) return becomes_v ? TAG_VPEND : TAG_TAKEN;
    return cur;
  endfunction

  function automatic logic [1:0] dual_rails(input logic p, input logic n, input logic neg);
    return {p ^ neg, n ^ neg};
  endfunction

endpackage

// File: rtl/hdb3_zero_window.sv
module hdb3_zero_window
  import hdb3_enc_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_in,
  input  logic      sub_en,
  input  logic      clear_tags,
  input  logic      need_b,
  output line_sym_e head_sym
);
  localparam int HEAD = RUN_LEN - 1;

  logic [RUN_LEN-1:0] data_q;
  slot_tag_e          tag_q [RUN_LEN];
  slot_tag_e          tag_d [RUN_LEN];
  logic               rest_zero;
  logic               sub_start;

  assign rest_zero = ~|data_q[HEAD-1:0];
  assign sub_start = sub_en && !clear_tags && !data_q[HEAD] &&
                     (tag_q[HEAD] == TAG_PLAIN) && rest_zero;

  assign tag_d[0] = TAG_PLAIN;
  for (genvar g = 1; g < RUN_LEN; g++) begin : g_tag
    assign tag_d[g] = slot_next_tag(clear_tags, sub_start, (g == 1), tag_q[g-1]);
  end

  always_comb begin
    if (data_q[HEAD])                  head_sym = SYM_MARK;
    else if (tag_q[HEAD] == TAG_VPEND) head_sym = SYM_VIOL;
    else if (sub_start && need_b)      head_sym = SYM_MARK;
    else                               head_sym = SYM_ZERO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      for (int i = 0; i < RUN_LEN; i++) tag_q[i] <= TAG_TAKEN;
    end else begin
      data_q <= {data_q[HEAD-1:0], bit_in};
      for (int i = 0; i < RUN_LEN; i++) tag_q[i] <= tag_d[i];
    end
  end
endmodule

// File: rtl/hdb3_pol_track.sv
module hdb3_pol_track
  import hdb3_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_sym_e  sym,
  input  logic       upd,
  output logic [1:0] rails,
  output logic       need_b
);
  logic mark_pol_q, viol_pol_q, was_v_q;
  logic sym_pol;

  assign sym_pol = (sym == SYM_VIOL) ? mark_pol_q : ~mark_pol_q;
  assign rails   = sym_to_rails(sym, sym_pol);
  assign need_b  = want_bpulse(mark_pol_q, viol_pol_q, was_v_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_pol_q <= 1'b0;
      viol_pol_q <= 1'b1;
      was_v_q    <= 1'b0;
    end else if (upd) begin
      if (sym == SYM_MARK) begin
        mark_pol_q <= sym_pol;
        was_v_q    <= 1'b0;
      end else if (sym == SYM_VIOL) begin
        viol_pol_q <= sym_pol;
        was_v_q    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdb3_rail_select.sv
module hdb3_rail_select
  import hdb3_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ais_tx,
  input  logic       loop_remote,
  input  logic       dual_rail,
  input  logic       mode2_neg,
  input  logic [1:0] enc_rails,
  input  logic       tx_p_in,
  input  logic       tx_n_in,
  input  logic       rx_p,
  input  logic       rx_n,
  output logic       line_p,
  output logic       line_n
);
  logic [1:0] rails_d;

  always_comb begin
    if (ais_tx)           rails_d = enc_rails;
    else if (loop_remote) rails_d = {rx_p, rx_n};
    else if (dual_rail)   rails_d = dual_rails(tx_p_in, tx_n_in, mode2_neg);
    else                  rails_d = enc_rails;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {line_p, line_n} <= 2'b00;
    else        {line_p, line_n} <= rails_d;
  end
endmodule

// File: rtl/hdb3_line_encoder.sv
module hdb3_line_encoder
  import hdb3_enc_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_data,
  input  logic hdb3_en,
  input  logic dual_rail,
  input  logic mode2_neg,
  input  logic tx_p_in,
  input  logic tx_n_in,
  input  logic loop_remote,
  input  logic rx_p,
  input  logic rx_n,
  input  logic ais_tx,
  output logic line_p,
  output logic line_n
);
  line_sym_e  win_sym;
  line_sym_e  enc_sym;
  logic       enc_upd;
  logic       need_b;
  logic [1:0] enc_rails;

  // The sign history advances only when the encoder or the override owns the line.
  assign enc_upd = ais_tx | (~loop_remote & ~dual_rail);
  assign enc_sym = ais_tx ? SYM_MARK : win_sym;

  hdb3_zero_window #(.RUN_LEN(RUN_LEN)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (tx_data),
    .sub_en     (hdb3_en & ~dual_rail),
    .clear_tags (ais_tx),
    .need_b     (need_b),
    .head_sym   (win_sym)
  );

  hdb3_pol_track u_pol (
    .clk    (clk),
    .rst_n  (rst_n),
    .sym    (enc_sym),
    .upd    (enc_upd),
    .rails  (enc_rails),
    .need_b (need_b)
  );

  hdb3_rail_select u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .ais_tx      (ais_tx),
    .loop_remote (loop_remote),
    .dual_rail   (dual_rail),
    .mode2_neg   (mode2_neg),
    .enc_rails   (enc_rails),
    .tx_p_in     (tx_p_in),
    .tx_n_in     (tx_n_in),
    .rx_p        (rx_p),
    .rx_n        (rx_n),
    .line_p      (line_p),
    .line_n      (line_n)
  );
endmodule

// File: rtl/hdb3_line_encoder_chk.sv
module hdb3_line_encoder_chk
  import hdb3_enc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      ais_tx,
  input logic      loop_remote,
  input logic      dual_rail,
  input logic      mode2_neg,
  input logic      tx_p_in,
  input logic      tx_n_in,
  input logic      rx_p,
  input logic      rx_n,
  input logic      line_p,
  input logic      line_n,
  input logic      enc_upd,
  input line_sym_e enc_sym
);
  // Own record of the sign of the last pulse the encoder put on the line.
  logic src_q, last_pol;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= 1'b0;
      last_pol <= 1'b0;
    end else begin
      src_q <= enc_upd;
      if (src_q && (line_p || line_n)) last_pol <= line_p;
    end
  end

  p_mark_flips_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_upd && enc_sym == SYM_MARK) |=> (line_p != last_pol) && (line_p != line_n));

  p_zero_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_upd && enc_sym == SYM_ZERO) |=> (!line_p && !line_n));

  p_viol_repeats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_upd && enc_sym == SYM_VIOL) |=> (line_p == last_pol) && (line_p != line_n));

  // R6 is covered by the mode2_neg term.
  p_dual_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ais_tx && !loop_remote && dual_rail) |=>
      (line_p == ($past(tx_p_in) ^ $past(mode2_neg))) &&
      (line_n == ($past(tx_n_in) ^ $past(mode2_neg))));

  p_loop_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ais_tx && loop_remote) |=> (line_p == $past(rx_p)) && (line_n == $past(rx_n)));

  p_ais_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ais_tx |=> (line_p != line_n));

  p_one_rail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enc_upd |=> !(line_p && line_n));
endmodule

bind hdb3_line_encoder hdb3_line_encoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ais_tx      (ais_tx),
  .loop_remote (loop_remote),
  .dual_rail   (dual_rail),
  .mode2_neg   (mode2_neg),
  .tx_p_in     (tx_p_in),
  .tx_n_in     (tx_n_in),
  .rx_p        (rx_p),
  .rx_n        (rx_n),
  .line_p      (line_p),
  .line_n      (line_n),
  .enc_upd     (enc_upd),
  .enc_sym     (enc_sym)
);

// File: tb/hdb3_line_encoder_bench.sv
module hdb3_line_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN    = 4;
  localparam int STREAM     = 48;
  localparam int CMP        = 40;
  localparam int ROWS       = 9;
  localparam int LAT        = RUN_LEN + 1;

  // {hdb3_en, 32-bit pattern sent MSB first, then zeros}
  localparam logic [32:0] VECS [ROWS] = '{
    {1'b0, 32'hFFFF_FFFF},
    {1'b0, 32'h8000_0001},
    {1'b1, 32'h0000_0000},
    {1'b1, 32'h8000_0000},
    {1'b1, 32'hC000_0000},
    {1'b1, 32'hA0F0_0801},
    {1'b1, 32'h1084_1084},
    {1'b0, 32'h0F0F_0000},
    {1'b1, 32'hFFFF_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_data = 1'b0, hdb3_en = 1'b0, dual_rail = 1'b0, mode2_neg = 1'b0;
  logic tx_p_in = 1'b0, tx_n_in = 1'b0, loop_remote = 1'b0;
  logic rx_p = 1'b0, rx_n = 1'b0, ais_tx = 1'b0;
  logic line_p, line_n;

  int total = 0;
  int bad = 0;
  logic exp_p [STREAM];
  logic exp_n [STREAM];

  hdb3_line_encoder #(.RUN_LEN(RUN_LEN)) u_hdb3_line_encoder (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .hdb3_en(hdb3_en),
    .dual_rail(dual_rail), .mode2_neg(mode2_neg), .tx_p_in(tx_p_in),
    .tx_n_in(tx_n_in), .loop_remote(loop_remote), .rx_p(rx_p), .rx_n(rx_n),
    .ais_tx(ais_tx), .line_p(line_p), .line_n(line_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rails actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic stream_bit(input logic [31:0] pat, input int k);
    return (k >= 0 && k < 32) ? pat[31-k] : 1'b0;
  endfunction

  // Reference: choose B00V when the pulse count since the last V is even.
  task automatic build_expect(input logic use_sub, input logic [31:0] pat);
    logic sign = 1'b0;
    int   since_v = 1;
    int   i = 0;
    logic quiet;
    for (int k = 0; k < STREAM; k++) begin exp_p[k] = 1'b0; exp_n[k] = 1'b0; end
    while (i < STREAM) begin
      quiet = (i + RUN_LEN <= STREAM);
      for (int j = 0; j < RUN_LEN; j++) if (stream_bit(pat, i + j)) quiet = 1'b0;
      if (use_sub && quiet) begin
        if (since_v % 2 == 0) begin
          sign = ~sign; exp_p[i] = sign; exp_n[i] = ~sign;
        end
        exp_p[i+RUN_LEN-1] = sign; exp_n[i+RUN_LEN-1] = ~sign;
        since_v = 0;
        i += RUN_LEN;
      end else begin
        if (stream_bit(pat, i)) begin
          sign = ~sign; exp_p[i] = sign; exp_n[i] = ~sign; since_v++;
        end
        i++;
      end
    end
  endtask

  task automatic do_reset(input logic first_bit);
    @(negedge clk);
    rst_n = 1'b0;
    tx_data = 1'b0;
    #1 check("R4 reset", {line_p, line_n}, 2'b00);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tx_data = first_bit;
  endtask

  initial begin
    // Table-driven streams
    for (int r = 0; r < ROWS; r++) begin
      string tag;
      hdb3_en = VECS[r][32];
      build_expect(VECS[r][32], VECS[r][31:0]);
      tag = (r == 2) ? "R4" : (VECS[r][32] ? "R3" : "R1");
      do_reset(stream_bit(VECS[r][31:0], 0));
      for (int cyc = 1; cyc <= CMP + LAT - 1; cyc++) begin
        @(negedge clk);
        if (cyc - LAT >= 0)
          check(tag, {line_p, line_n}, {exp_p[cyc-LAT], exp_n[cyc-LAT]});
        tx_data = stream_bit(VECS[r][31:0], cyc);
      end
    end

    // R2: single one, exact output cycle
    hdb3_en = 1'b0;
    do_reset(1'b1);
    for (int cyc = 1; cyc <= LAT + 1; cyc++) begin
      @(negedge clk);
      tx_data = 1'b0;
      if (cyc == LAT - 1) check("R2 early", {line_p, line_n}, 2'b00);
      if (cyc == LAT)     check("R2 on time", {line_p, line_n}, 2'b10);
      if (cyc == LAT + 1) check("R2 after", {line_p, line_n}, 2'b00);
    end

    // R5 / R6: dual-rail pass-through
    do_reset(1'b0);
    dual_rail = 1'b1; hdb3_en = 1'b1;
    tx_p_in = 1'b1; tx_n_in = 1'b0;
    @(negedge clk); check("R5 p", {line_p, line_n}, 2'b10);
    tx_p_in = 1'b0; tx_n_in = 1'b1;
    @(negedge clk); check("R5 n", {line_p, line_n}, 2'b01);
    tx_p_in = 1'b0; tx_n_in = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); check("R5 zeros no substitution", {line_p, line_n}, 2'b00);
    end
    mode2_neg = 1'b1;
    tx_p_in = 1'b0; tx_n_in = 1'b1;
    @(negedge clk); check("R6 low p", {line_p, line_n}, 2'b10);
    tx_p_in = 1'b1; tx_n_in = 1'b1;
    @(negedge clk); check("R6 idle", {line_p, line_n}, 2'b00);
    tx_p_in = 1'b1; tx_n_in = 1'b0;
    @(negedge clk); check("R6 low n", {line_p, line_n}, 2'b01);
    mode2_neg = 1'b0; dual_rail = 1'b0; tx_p_in = 1'b0; tx_n_in = 1'b0;

    // R7: remote loopback
    loop_remote = 1'b1; tx_data = 1'b1;
    rx_p = 1'b1; rx_n = 1'b0;
    @(negedge clk); check("R7 p", {line_p, line_n}, 2'b10);
    rx_p = 1'b0; rx_n = 1'b1;
    @(negedge clk); check("R7 n", {line_p, line_n}, 2'b01);
    rx_p = 1'b0; rx_n = 1'b0;
    @(negedge clk); check("R7 quiet", {line_p, line_n}, 2'b00);
    loop_remote = 1'b0;

    // R8 / R9 / R10: override over loopback, sign continuity
    hdb3_en = 1'b0;
    do_reset(1'b1);
    begin
      logic prev = 1'b0;
      for (int cyc = 1; cyc <= 24; cyc++) begin
        @(negedge clk);
        if (cyc < LAT) begin
          check("R10 fill", {line_p, line_n}, 2'b00);
        end else begin
          string tag;
          tag = (cyc >= 11 && cyc <= 14) ? "R8" :
                ((cyc == 10 || cyc == 15 || cyc == 16) ? "R9" : "R10");
          check(tag, {line_p, line_n}, prev ? 2'b01 : 2'b10);
          prev = ~prev;
        end
        if (cyc == 10) begin
          ais_tx = 1'b1; loop_remote = 1'b1; rx_p = 1'b1; rx_n = 1'b1;
        end
        if (cyc == 14) begin
          ais_tx = 1'b0; loop_remote = 1'b0; rx_p = 1'b0; rx_n = 1'b0;
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule